// File: doc/BRIEF.md
# Serial-Controlled SAR Conversion Sequencer

This block is the digital core of an 8-bit successive-approximation converter that a host controls over a three-wire serial link. It waits for a leading one on the data input and then shifts in a short channel-assignment word. It decodes that word into a positive and a negative analog input selection. The analog multiplexer, the reference ladder and the comparator sit outside the block. The block drives an 8-bit trial code to the ladder and reads back one comparator bit per clock.

After a one-period settling slot, the block resolves one result bit per clock. It sends each bit out as soon as it is known, most significant bit first. It then replays the result from bit 1 upward, so the least significant bit is not sent twice. On the eight-channel build, a hold input can keep the least significant bit on the line until the host is ready for the replay. Outputs change on the falling clock edge, so the host samples them on the rising edge. Chip select high aborts any transaction and clears all state. The data and busy outputs come with separate drive enables that control a tristate pad.

Top module: `sar_serial_seq`

## Requirements
- R1: While cs_n is high, dout_en and busy_en are 0 and all state is cleared. A transaction aborted this way leaves no trace in the next one. busy_en equals the inverse of cs_n.
- R2: On the rising clock edge, zeros on din before the first one are skipped, and the first one is taken as the start bit. Until the address word is complete, dout_en stays 0 and busy stays 0.
- R3: The four rising edges after the start bit capture, in order, the mode bit (1 = single-ended), the odd/sign bit, the upper select bit and the lower select bit. In single-ended mode, mux_pos = {sel_hi, sel_lo, odd} and mux_com = 1, which means the common terminal is the negative input.
- R4: In differential mode (mode bit 0), mux_com = 0 and the pair is {sel_hi, sel_lo, x}. The odd/sign bit picks the positive member: mux_pos = {sel_hi, sel_lo, odd} and mux_neg = {sel_hi, sel_lo, ~odd}.
- R5: At the falling edge after the last address bit is captured, busy goes to 1 and dout is driven to 0 (dout_en = 1) for one settling period.
- R6: Once the address word is complete, din has no effect. The mux selection stays fixed and the result is unchanged until cs_n rises.
- R7: busy stays 1 for exactly 9 clock periods (settling plus 8 bit periods) and then drives 0.
- R8: During bit period k (k from 7 down to 0), trial_code equals the already-resolved upper bits with bit k set. cmp_ge = 1 (the input is at or above the trial code) keeps bit k, and 0 clears it. The same comparator value appears on dout in that period. The final code is max(pos - neg, 0).
- R9: After bit 0, dout carries result bits 1 through 7, one per period, in that order. Bit 0 is not repeated.
- R10: If lsb_hold is 1 at the rising edge that ends bit period 0, dout keeps result bit 0 on the line. It stays there for every following period in which lsb_hold is still 1 at the rising edge. The replay of bit 1 starts in the period after the first rising edge that sees lsb_hold at 0.
- R11: After result bit 7 of the replay, dout_en returns to 0 and stays 0 until cs_n rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset |
| clk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low chip select; high clears the block |
| din | input | 1 | Serial address input, sampled on the rising edge |
| lsb_hold | input | 1 | High keeps the least significant bit on dout before the replay |
| cmp_ge | input | 1 | Comparator result: 1 = analog input is at or above trial_code |
| trial_code | output | 8 | Code presented to the external ladder |
| mux_en | output | 1 | The address word is complete and the mux selection is valid |
| mux_pos | output | 3 | Channel index of the positive input |
| mux_neg | output | 3 | Channel index of the negative input (differential mode) |
| mux_com | output | 1 | 1 = the common terminal is the negative input |
| dout | output | 1 | Serial data value |
| dout_en | output | 1 | Pad drive enable for dout |
| busy | output | 1 | Conversion in progress |
| busy_en | output | 1 | Pad drive enable for busy |

## Verification
The bench drives random channel voltages against random address words with zero to three leading zeros. This shows whether start-bit detection and field order are right, because a one-bit framing slip changes the selected channel and hence the code. Directed cases set a negative difference, two equal inputs and a full-scale difference. These separate the clamp to zero, the at-or-above comparison at equality, and a search that keeps every trial bit. Hold lengths of zero, one and three tell apart a replay that repeats the least significant bit from one that skips it. Random din during conversion and a chip-select abort in mid-conversion show whether input and old state are really ignored.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_WAIT   = 3'd0,
    ST_ADDR   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_CONV   = 3'd3,
    ST_HOLD   = 3'd4,
    ST_REPLAY = 3'd5,
    ST_DONE   = 3'd6
  } seq_state_e;

endpackage

// File: rtl/sar_addr_unit.sv
// Address shift register and channel/polarity decode.
module sar_addr_unit #(
  parameter int NUM_CH = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int SEL_W  = CH_W - 1,
  localparam int ADDR_W = SEL_W + 2
) (
  input  logic            clk,
  input  logic            clr_n,
  input  logic            shift_en,
  input  logic            din,
  output logic [CH_W-1:0] pos_idx,
  output logic [CH_W-1:0] neg_idx,
  output logic            neg_com
);

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_d;
  logic              mode_single;
  logic              odd_sign;
  logic [SEL_W-1:0]  sel;

  always_comb begin
    addr_d = addr_q;
    if (shift_en) begin
      addr_d = {addr_q[ADDR_W-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
    end
  end

  // First bit captured ends up at the top of the register.
  assign mode_single = addr_q[ADDR_W-1];
  assign odd_sign    = addr_q[ADDR_W-2];
  assign sel         = addr_q[SEL_W-1:0];

  always_comb begin
    pos_idx = {sel, odd_sign};
    if (mode_single) begin
      neg_idx = '0;
      neg_com = 1'b1;
    end else begin
      neg_idx = {sel, ~odd_sign};
      neg_com = 1'b0;
    end
  end

endmodule

// File: rtl/sar_search.sv
// Successive-approximation result register and trial code.
module sar_search #(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              clr_n,
  input  logic              clear,
  input  logic              resolve_en,
  input  logic [IDX_W-1:0]  bit_idx,
  input  logic              cmp_ge,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] trial
);

  logic [DATA_W-1:0] res_q;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] probe;

  assign probe = DATA_W'(1) << bit_idx;

  always_comb begin
    res_d = res_q;
    if (clear) begin
      res_d = '0;
    end else if (resolve_en) begin
      res_d = cmp_ge ? (res_q | probe) : (res_q & ~probe);
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      res_q <= '0;
    end else begin
      res_q <= res_d;
    end
  end

  assign result = res_q;
  assign trial  = resolve_en ? (res_q | probe) : res_q;

endmodule

// File: rtl/sar_out_stage.sv
// Falling-edge output registers: data, its enable and busy.
module sar_out_stage (
  input  logic clk,
  input  logic clr_n,
  input  logic drive_nxt,
  input  logic bit_nxt,
  input  logic busy_nxt,
  output logic dout,
  output logic dout_en,
  output logic busy
);

  logic dout_q;
  logic den_q;
  logic busy_q;

  always_ff @(negedge clk or negedge clr_n) begin
    if (!clr_n) begin
      dout_q <= 1'b0;
      den_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      dout_q <= drive_nxt & bit_nxt;
      den_q  <= drive_nxt;
      busy_q <= busy_nxt;
    end
  end

  assign dout    = dout_q;
  assign dout_en = den_q;
  assign busy    = busy_q;

endmodule

// File: rtl/sar_serial_seq.sv
module sar_serial_seq
  import sar_seq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 8,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int ADDR_W = CH_W + 1,
  localparam int CNT_W  = $clog2(DATA_W)
) (
  input  logic              rst_n,
  input  logic              clk,
  input  logic              cs_n,
  input  logic              din,
  input  logic              lsb_hold,
  input  logic              cmp_ge,
  output logic [DATA_W-1:0] trial_code,
  output logic              mux_en,
  output logic [CH_W-1:0]   mux_pos,
  output logic [CH_W-1:0]   mux_neg,
  output logic              mux_com,
  output logic              dout,
  output logic              dout_en,
  output logic              busy,
  output logic              busy_en
);

  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] BIT_TOP   = CNT_W'(DATA_W - 1);

  logic              clr_n;
  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              shift_en;
  logic              hold_req;
  logic [DATA_W-1:0] result;
  logic              drive_nxt;
  logic              bit_nxt;
  logic              busy_nxt;

  // Chip select high acts as a clear of the whole block.
  assign clr_n = rst_n & ~cs_n;

  generate
    if (NUM_CH > 4) begin : g_hold
      assign hold_req = lsb_hold;
    end else begin : g_nohold
      assign hold_req = 1'b0;
    end
  endgenerate

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    shift_en = 1'b0;
    case (st_q)
      ST_WAIT: begin
        if (din) begin
          st_d  = ST_ADDR;
          cnt_d = '0;
        end
      end
      ST_ADDR: begin
        shift_en = 1'b1;
        if (cnt_q == ADDR_LAST) begin
          st_d = ST_SETTLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_SETTLE: begin
        st_d  = ST_CONV;
        cnt_d = BIT_TOP;
      end
      ST_CONV: begin
        if (cnt_q == '0) begin
          st_d  = hold_req ? ST_HOLD : ST_REPLAY;
          cnt_d = CNT_W'(1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: begin
        if (!hold_req) begin
          st_d = ST_REPLAY;
        end
      end
      ST_REPLAY: begin
        if (cnt_q == BIT_TOP) begin
          st_d = ST_DONE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        st_d = st_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      st_q  <= ST_WAIT;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  sar_addr_unit #(.NUM_CH(NUM_CH)) i_addr (
    .clk      (clk),
    .clr_n    (clr_n),
    .shift_en (shift_en),
    .din      (din),
    .pos_idx  (mux_pos),
    .neg_idx  (mux_neg),
    .neg_com  (mux_com)
  );

  sar_search #(.DATA_W(DATA_W)) i_search (
    .clk        (clk),
    .clr_n      (clr_n),
    .clear      (st_q == ST_SETTLE),
    .resolve_en (st_q == ST_CONV),
    .bit_idx    (cnt_q),
    .cmp_ge     (cmp_ge),
    .result     (result),
    .trial      (trial_code)
  );

  // Values the falling edge loads into the output stage.
  always_comb begin
    drive_nxt = 1'b0;
    bit_nxt   = 1'b0;
    busy_nxt  = 1'b0;
    case (st_q)
      ST_SETTLE: begin
        drive_nxt = 1'b1;
        busy_nxt  = 1'b1;
      end
      ST_CONV: begin
        drive_nxt = 1'b1;
        bit_nxt   = cmp_ge;
        busy_nxt  = 1'b1;
      end
      ST_HOLD: begin
        drive_nxt = 1'b1;
        bit_nxt   = result[0];
      end
      ST_REPLAY: begin
        drive_nxt = 1'b1;
        bit_nxt   = result[cnt_q];
      end
      default: begin
        drive_nxt = 1'b0;
      end
    endcase
  end

  sar_out_stage i_out (
    .clk       (clk),
    .clr_n     (clr_n),
    .drive_nxt (drive_nxt),
    .bit_nxt   (bit_nxt),
    .busy_nxt  (busy_nxt),
    .dout      (dout),
    .dout_en   (dout_en),
    .busy      (busy)
  );

  assign mux_en  = (st_q != ST_WAIT) && (st_q != ST_ADDR);
  assign busy_en = ~cs_n;

endmodule

// File: rtl/sar_serial_seq_chk.sv
module sar_serial_seq_chk #(
  parameter int DATA_W = 8,
  parameter int CH_W   = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cs_n,
  input logic            dout,
  input logic            dout_en,
  input logic            busy,
  input logic            busy_en,
  input logic            mux_en,
  input logic [CH_W-1:0] mux_pos,
  input logic [CH_W-1:0] mux_neg,
  input logic            mux_com
);

  localparam int RUN_W = $clog2(DATA_W + 2) + 1;
  localparam logic [RUN_W-1:0] RUN_LEN = RUN_W'(DATA_W + 1);

  logic             busy_b;
  logic [RUN_W-1:0] run_q;

  assign busy_b = busy & busy_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (!busy_b) begin
      run_q <= '0;
    end else if (run_q != '1) begin
      run_q <= run_q + 1'b1;
    end
  end

  AST_CS_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (!dout_en && !busy_en)); // R1

  AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !mux_en) |-> (!dout_en && !busy)); // R2

  AST_SETTLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_b) |-> (dout_en && !dout)); // R5

  AST_MUX_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_b && $past(busy_b)) |-> $stable({mux_pos, mux_neg, mux_com})); // R6

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy_b) && !cs_n) |-> (run_q == RUN_LEN)); // R7

  AST_BUSY_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_LEN); // R7

endmodule

bind sar_serial_seq sar_serial_seq_chk #(.DATA_W(DATA_W), .CH_W(CH_W)) i_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .cs_n    (cs_n),
  .dout    (dout),
  .dout_en (dout_en),
  .busy    (busy),
  .busy_en (busy_en),
  .mux_en  (mux_en),
  .mux_pos (mux_pos),
  .mux_neg (mux_neg),
  .mux_com (mux_com)
);

// File: tb/test_sar_serial_seq.sv
`timescale 1ns/1ps
module test_sar_serial_seq;

  logic       clk;
  logic       rst_n;
  logic       cs_n;
  logic       din;
  logic       lsb_hold;
  logic       cmp_ge;
  logic [7:0] trial_code;
  logic       mux_en;
  logic [2:0] mux_pos;
  logic [2:0] mux_neg;
  logic       mux_com;
  logic       dout;
  logic       dout_en;
  logic       busy;
  logic       busy_en;

  int n_tests;
  int n_fail;
  int chan_v [8];
  int com_v;
  bit finished;

  sar_serial_seq i_sar_serial_seq (
    .rst_n      (rst_n),
    .clk        (clk),
    .cs_n       (cs_n),
    .din        (din),
    .lsb_hold   (lsb_hold),
    .cmp_ge     (cmp_ge),
    .trial_code (trial_code),
    .mux_en     (mux_en),
    .mux_pos    (mux_pos),
    .mux_neg    (mux_neg),
    .mux_com    (mux_com),
    .dout       (dout),
    .dout_en    (dout_en),
    .busy       (busy),
    .busy_en    (busy_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Analog front-end model: multiplexer, ladder and comparator.
  always_comb begin
    int p;
    int n;
    p = chan_v[mux_pos];
    n = mux_com ? com_v : chan_v[mux_neg];
    cmp_ge = ((p - n) >= int'(trial_code));
  end

  function automatic int expect_code(bit sgl, bit odd, bit [1:0] sel);
    int p;
    int n;
    p = chan_v[{sel, odd}];
    n = sgl ? com_v : chan_v[{sel, ~odd}];
    return (p > n) ? (p - n) : 0;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Lands between the falling edge and the next rising edge.
  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic run_txn(bit sgl, bit odd, bit [1:0] sel, int lead,
                         int hold_len, int abort_at);
    int code;
    int total;
    bit bitv;
    bit [3:0] word;
    code  = expect_code(sgl, odd, sel);
    word  = {sgl, odd, sel};
    total = lead + 5;
    lsb_hold = (hold_len > 0);
    for (int i = 0; i < total; i++) begin
      if (i > 0) begin
        check("R2", "dout_en while addressing", int'(dout_en), 0);
        check("R2", "busy while addressing", int'(busy), 0);
      end
      if (i < lead) bitv = 1'b0;
      else if (i == lead) bitv = 1'b1;
      else bitv = word[3 - (i - lead - 1)];
      cs_n = 1'b0;
      din  = bitv;
      step();
    end
    check("R5", "busy at settle", int'(busy && busy_en), 1);
    check("R5", "dout_en at settle", int'(dout_en), 1);
    check("R5", "dout at settle", int'(dout), 0);
    check("R3", "mux_pos", int'(mux_pos), int'({sel, odd}));
    check("R3", "mux_com", int'(mux_com), int'(sgl));
    if (!sgl) check("R4", "mux_neg", int'(mux_neg), int'({sel, ~odd}));
    din = 1'($urandom);
    step();
    for (int b = 7; b >= 0; b--) begin
      int hi;
      hi = code & (256 - (1 << (b + 1)));
      check("R8", "trial_code", int'(trial_code), hi | (1 << b));
      check("R8", "msb-first bit", int'(dout && dout_en), (code >> b) & 1);
      check("R7", "busy during conversion", int'(busy), 1);
      if (abort_at == b) begin
        cs_n = 1'b1;
        step();
        check("R1", "dout_en after abort", int'(dout_en), 0);
        check("R1", "busy_en after abort", int'(busy_en), 0);
        din = 1'b0;
        return;
      end
      din = 1'($urandom);
      step();
    end
    for (int h = 0; h < hold_len; h++) begin
      check("R10", "held lsb", int'(dout && dout_en), code & 1);
      check("R7", "busy after conversion", int'(busy), 0);
      if (h == hold_len - 1) lsb_hold = 1'b0;
      din = 1'($urandom);
      step();
    end
    for (int j = 1; j < 8; j++) begin
      check("R9", "lsb-first bit", int'(dout && dout_en), (code >> j) & 1);
      check("R7", "busy during replay", int'(busy), 0);
      din = 1'($urandom);
      step();
    end
    check("R11", "dout_en after replay", int'(dout_en), 0);
    step();
    check("R11", "dout_en stays off", int'(dout_en), 0);
    check("R6", "mux_pos kept", int'(mux_pos), int'({sel, odd}));
    cs_n = 1'b1;
    din  = 1'b0;
    step();
    check("R1", "dout_en with cs high", int'(dout_en), 0);
    check("R1", "busy_en with cs high", int'(busy_en), 0);
    check("R1", "mux_en cleared", int'(mux_en), 0);
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    cs_n  = 1'b1;
    din   = 1'b0;
    lsb_hold = 1'b0;
    com_v = 0;
    for (int c = 0; c < 8; c++) chan_v[c] = 0;
    void'($urandom(32'h5A17));
    step();
    step();
    check("R1", "reset dout_en", int'(dout_en), 0);
    check("R1", "reset busy_en", int'(busy_en), 0);
    check("R1", "reset mux_en", int'(mux_en), 0);
    rst_n = 1'b1;
    step();

    // Full scale, single-ended channel 0 against a common of zero.
    chan_v[0] = 255; com_v = 0;
    run_txn(1'b1, 1'b0, 2'b00, 2, 0, -1);
    // Negative difference clamps to zero: channel 2 positive, 3 negative.
    chan_v[2] = 10; chan_v[3] = 200;
    run_txn(1'b0, 1'b0, 2'b01, 0, 0, -1);
    // Same pair with reversed polarity.
    run_txn(1'b0, 1'b1, 2'b01, 1, 1, -1);
    // Equal inputs give zero.
    chan_v[5] = 77; com_v = 77;
    run_txn(1'b1, 1'b1, 2'b10, 3, 3, -1);
    // Abort mid-conversion, then a clean transaction.
    chan_v[6] = 201; chan_v[7] = 3;
    run_txn(1'b0, 1'b0, 2'b11, 1, 0, 4);
    run_txn(1'b0, 1'b0, 2'b11, 0, 2, -1);

    for (int t = 0; t < 40; t++) begin
      for (int c = 0; c < 8; c++) chan_v[c] = int'($urandom_range(0, 255));
      com_v = int'($urandom_range(0, 255));
      run_txn(1'($urandom), 1'($urandom), 2'($urandom),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              ((t % 9) == 4) ? int'($urandom_range(0, 7)) : -1);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule